// File: doc/BRIEF.md
# Strided Banked Vector Address Generator

This block turns one strided vector memory operation into a stream of element requests to a memory built from 16 independent one-word banks. It takes a word base address, a signed word stride and a vector length. Element i goes to base + i × stride, and its bank is the low four bits of that word address. The block sends at most one request per cycle. Each bank needs time to recover after an access, so the block holds back any element whose bank is still busy. That makes the stride decide the rate: a unit stride streams at one element per cycle, and a stride that is a multiple of 16 gets one request through every four cycles.

For a load, the banks return data a fixed 12 cycles after each request. The block pairs each returned word with the element index it belongs to, so a vector register file can write it to the right slot. A one-cycle done pulse closes each operation. For a store it comes after the last request. For a load it comes after the last data has returned.

Top module: `stride_agu`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, busy_o, done_o, req_valid_o and rsp_valid_o are all 0.
- R2: The request for element i carries req_addr_o = base + i × stride. The stride is two's complement, and the sum wraps modulo 2^32.
- R3: req_bank_o equals req_addr_o[3:0], the bank that serves the word.
- R4: After a request to a bank in cycle t, no other request goes to that bank before cycle t+4.
- R5: Elements are issued strictly in index order, at most one per cycle. When the next element's bank is busy, no request is made that cycle and the element does not advance. When its bank is free, it is issued in that cycle.
- R6: A started operation makes exactly vlen requests, with req_idx_o running 0 to vlen−1.
- R7: A load request made in cycle t has rsp_valid_o high in cycle t+12, with rsp_idx_o set to that element's index and rsp_data_o equal to mem_rdata_i in that cycle.
- R8: done_o is a one-cycle pulse. For a store it comes in the cycle after the last request. For a load it comes in the cycle after the last response. busy_o is high from the cycle after the start until the done cycle, and low in the done cycle.
- R9: A start with vlen_i = 0 makes no request and pulses done_o in the next cycle.
- R10: start_i is ignored while busy_o is high. It changes neither the requests nor the completion of the running operation.
- R11: req_we_o is 1 for the requests of a store operation (load_i = 0) and 0 for those of a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts an operation when the block is idle |
| load_i | input | 1 | 1 = load, 0 = store |
| base_i | input | 32 | Word base address |
| stride_i | input | 32 | Signed word stride |
| vlen_i | input | 7 | Number of elements (0 to 64 used) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion pulse |
| req_valid_o | output | 1 | Element request this cycle |
| req_we_o | output | 1 | Request is a write |
| req_addr_o | output | 32 | Element word address |
| req_bank_o | output | 4 | Target bank |
| req_idx_o | output | 7 | Element index |
| mem_rdata_i | input | 64 | Bank read data, valid 12 cycles after a load request |
| rsp_valid_o | output | 1 | Load data returned this cycle |
| rsp_idx_o | output | 7 | Element index of returned data |
| rsp_data_o | output | 64 | Returned data |

## Verification
The bench runs unit, negative, bank-aliasing (stride 16), half-aliasing (stride 8) and odd strides, comparing every output each cycle against a behavioural model. That model holds a ready time for each bank. An off-by-one recovery counter would show up as requests one cycle early or late on the aliasing strides. Reading the bank from the wrong address bits would break the full-rate unit-stride case. A misaligned return pipeline would put data on the wrong element or the wrong cycle. A zero-length start that still issues, or that never pulses done, is caught by its own case. A start pulse in the middle of an operation checks that a restart does not corrupt the running address stream.

// File: rtl/stride_agu_pkg.sv
package stride_agu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } agu_state_e;
endpackage

// File: rtl/stride_agu_bank_timer.sv
module stride_agu_bank_timer #(
  parameter int NUM_BANKS = 16,
  parameter int BUSY_CYC  = 4,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hit_i,
  input  logic [BANK_W-1:0]    hit_bank_i,
  output logic [NUM_BANKS-1:0] free_o
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [CNT_W-1:0] cnt_q;
    logic             hit;

    assign hit       = hit_i && (hit_bank_i == BANK_W'(g));
    assign free_o[g] = (cnt_q == '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           cnt_q <= '0;
      else if (hit)          cnt_q <= CNT_W'(BUSY_CYC - 1);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    // R4: an access may only land on a bank whose recovery window has closed
    p_bank_rest_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit |-> cnt_q == '0);
  end
endmodule

// File: rtl/stride_agu_ret_pipe.sv
module stride_agu_ret_pipe #(
  parameter int LAT   = 12,
  parameter int LEN_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [LEN_W-1:0] idx_i,
  output logic             valid_o,
  output logic [LEN_W-1:0] idx_o
);
  logic [LAT-1:0]   v_q;
  logic [LEN_W-1:0] idx_q [LAT];

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    logic             v_in;
    logic [LEN_W-1:0] idx_in;
    if (g == 0) begin : g_head
      assign v_in   = push_i;
      assign idx_in = idx_i;
    end else begin : g_body
      assign v_in   = v_q[g-1];
      assign idx_in = idx_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q[g]   <= 1'b0;
        idx_q[g] <= '0;
      end else begin
        v_q[g]   <= v_in;
        idx_q[g] <= idx_in;
      end
    end
  end

  assign valid_o = v_q[LAT-1];
  assign idx_o   = idx_q[LAT-1];
endmodule

// File: rtl/stride_agu_issue.sv
module stride_agu_issue
  import stride_agu_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 7,
  parameter int NUM_BANKS = 16,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 load_i,
  input  logic [ADDR_W-1:0]    base_i,
  input  logic [ADDR_W-1:0]    stride_i,
  input  logic [LEN_W-1:0]     vlen_i,
  input  logic [NUM_BANKS-1:0] bank_free_i,
  input  logic                 rsp_valid_i,
  input  logic [LEN_W-1:0]     rsp_idx_i,
  output logic                 issue_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [BANK_W-1:0]    bank_o,
  output logic [LEN_W-1:0]     idx_o,
  output logic                 we_o,
  output logic                 busy_o,
  output logic                 done_o
);
  agu_state_e        state_q;
  logic [ADDR_W-1:0] addr_q, stride_q;
  logic [LEN_W-1:0]  len_q, idx_q, last_idx;
  logic              load_q, done_q, last_issue;

  assign bank_o     = addr_q[BANK_W-1:0];
  assign issue_o    = (state_q == ST_ISSUE) && bank_free_i[bank_o];
  assign last_idx   = len_q - 1'b1;
  assign last_issue = (idx_q == last_idx);
  assign addr_o     = addr_q;
  assign idx_o      = idx_q;
  assign we_o       = !load_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      stride_q <= '0;
      len_q    <= '0;
      idx_q    <= '0;
      load_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          load_q   <= load_i;
          addr_q   <= base_i;
          stride_q <= stride_i;
          len_q    <= vlen_i;
          idx_q    <= '0;
          if (vlen_i == '0) done_q  <= 1'b1;
          else              state_q <= ST_ISSUE;
        end
        ST_ISSUE: if (issue_o) begin
          addr_q <= addr_q + stride_q;
          idx_q  <= idx_q + 1'b1;
          if (last_issue) begin
            if (load_q) state_q <= ST_DRAIN;
            else begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        ST_DRAIN: if (rsp_valid_i && rsp_idx_i == last_idx) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R5: a stalled element keeps its index and address
  p_stall_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ISSUE && !issue_o) |=> $stable(idx_q) && $stable(addr_q));

  // R8: completion cycle is quiet and idle
  p_done_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !issue_o && !busy_o);
endmodule

// File: rtl/stride_agu.sv
module stride_agu #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 7,
  parameter int DATA_W    = 64,
  parameter int NUM_BANKS = 16,
  parameter int BUSY_CYC  = 4,
  parameter int LAT       = 12
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic                          load_i,
  input  logic [ADDR_W-1:0]             base_i,
  input  logic [ADDR_W-1:0]             stride_i,
  input  logic [LEN_W-1:0]              vlen_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic                          req_valid_o,
  output logic                          req_we_o,
  output logic [ADDR_W-1:0]             req_addr_o,
  output logic [$clog2(NUM_BANKS)-1:0]  req_bank_o,
  output logic [LEN_W-1:0]              req_idx_o,
  input  logic [DATA_W-1:0]             mem_rdata_i,
  output logic                          rsp_valid_o,
  output logic [LEN_W-1:0]              rsp_idx_o,
  output logic [DATA_W-1:0]             rsp_data_o
);
  localparam int BANK_W = $clog2(NUM_BANKS);

  logic [NUM_BANKS-1:0] bank_free;
  logic                 issue, we;

  stride_agu_issue #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)
  ) u_issue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .load_i      (load_i),
    .base_i      (base_i),
    .stride_i    (stride_i),
    .vlen_i      (vlen_i),
    .bank_free_i (bank_free),
    .rsp_valid_i (rsp_valid_o),
    .rsp_idx_i   (rsp_idx_o),
    .issue_o     (issue),
    .addr_o      (req_addr_o),
    .bank_o      (req_bank_o),
    .idx_o       (req_idx_o),
    .we_o        (we),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  stride_agu_bank_timer #(
    .NUM_BANKS(NUM_BANKS), .BUSY_CYC(BUSY_CYC), .BANK_W(BANK_W)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (issue),
    .hit_bank_i (req_bank_o),
    .free_o     (bank_free)
  );

  stride_agu_ret_pipe #(.LAT(LAT), .LEN_W(LEN_W)) u_ret (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (issue && !we),
    .idx_i   (req_idx_o),
    .valid_o (rsp_valid_o),
    .idx_o   (rsp_idx_o)
  );

  assign req_valid_o = issue;
  assign req_we_o    = we;
  assign rsp_data_o  = mem_rdata_i;

  // R7: returned data only while an operation is open
  p_rsp_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> busy_o);
endmodule

// File: tb/stride_agu_tb_top.sv
`timescale 1ns/1ps
module stride_agu_tb_top;
  localparam int LAT = 12;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, load_i = 1'b0;
  logic [31:0] base_i = '0, stride_i = '0;
  logic [6:0]  vlen_i = '0;
  logic        busy_o, done_o, req_valid_o, req_we_o, rsp_valid_o;
  logic [31:0] req_addr_o;
  logic [3:0]  req_bank_o;
  logic [6:0]  req_idx_o, rsp_idx_o;
  logic [63:0] mem_rdata_i = '0, rsp_data_o;

  always #2 clk_i = ~clk_i;

  stride_agu dut_i (
    .clk_i, .rst_ni, .start_i, .load_i, .base_i, .stride_i, .vlen_i,
    .busy_o, .done_o, .req_valid_o, .req_we_o, .req_addr_o, .req_bank_o,
    .req_idx_o, .mem_rdata_i, .rsp_valid_o, .rsp_idx_o, .rsp_data_o
  );

  int total = 0, bad = 0;
  int cyc = 0;
  int ops_done = 0;
  int req_cnt = 0;

  // reference model state
  int          m_st = 0;
  logic        m_load, m_zero = 1'b0, m_issue = 1'b0, exp_done = 1'b0;
  logic [31:0] m_addr, m_stride;
  int          m_len, m_idx, m_last_due;
  int          bank_ready [16];
  int          e_due [$];
  int          e_idx [$];
  logic [31:0] e_addr [$];
  int          mem_due [$];
  logic [31:0] mem_addr [$];

  function automatic logic [63:0] word_of(input logic [31:0] a);
    return {a ^ 32'h5a5a_0000, ~a};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    int c;
    c = cyc;
    exp_done = 1'b0;
    if (!rst_ni) begin
      m_st = 0;
      for (int b = 0; b < 16; b++) bank_ready[b] = 0;
      e_due.delete(); e_idx.delete(); e_addr.delete();
    end else begin
      case (m_st)
        0: if (start_i) begin
          m_load = load_i; m_addr = base_i; m_stride = stride_i;
          m_len = int'(vlen_i); m_idx = 0; m_zero = (vlen_i == 0);
          if (vlen_i == 0) begin exp_done = 1'b1; ops_done++; end
          else m_st = 1;
        end
        1: if (m_issue) begin
          bank_ready[m_addr[3:0]] = c + 4;
          if (m_load) begin e_due.push_back(c + LAT); e_idx.push_back(m_idx); e_addr.push_back(m_addr); end
          m_idx++;
          m_addr = m_addr + m_stride;
          if (m_idx == m_len) begin
            if (m_load) begin m_st = 2; m_last_due = c + LAT; end
            else begin m_st = 0; exp_done = 1'b1; ops_done++; end
          end
        end
        2: if (c == m_last_due) begin m_st = 0; exp_done = 1'b1; ops_done++; end
        default: m_st = 0;
      endcase
    end
    cyc = cyc + 1;
    if (mem_due.size() > 0 && mem_due[0] == cyc) begin
      mem_rdata_i = word_of(mem_addr[0]);
      void'(mem_due.pop_front()); void'(mem_addr.pop_front());
    end else mem_rdata_i = '0;
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      logic ev;
      m_issue = (m_st == 1) && (bank_ready[m_addr[3:0]] <= cyc);
      chk(busy_o == (m_st != 0), "R8 busy", busy_o, m_st != 0);
      chk(done_o == exp_done, m_zero ? "R9 done" : "R8 done", done_o, exp_done);
      chk(req_valid_o == m_issue, "R4 R5 req_valid", req_valid_o, m_issue);
      if (m_issue && req_valid_o) begin
        chk(req_addr_o == m_addr, "R2 addr", req_addr_o, m_addr);
        chk(req_bank_o == m_addr[3:0], "R3 bank", req_bank_o, m_addr[3:0]);
        chk(int'(req_idx_o) == m_idx, "R6 idx", req_idx_o, m_idx);
        chk(req_we_o == !m_load, "R11 we", req_we_o, !m_load);
      end
      ev = (e_due.size() > 0) && (e_due[0] == cyc);
      chk(rsp_valid_o == ev, "R7 rsp_valid", rsp_valid_o, ev);
      if (ev) begin
        if (rsp_valid_o) begin
          chk(int'(rsp_idx_o) == e_idx[0], "R7 rsp_idx", rsp_idx_o, e_idx[0]);
          chk(rsp_data_o == word_of(e_addr[0]), "R7 rsp_data", rsp_data_o, word_of(e_addr[0]));
        end
        void'(e_due.pop_front()); void'(e_idx.pop_front()); void'(e_addr.pop_front());
      end
      if (req_valid_o) begin
        req_cnt++;
        if (!req_we_o) begin mem_due.push_back(cyc + LAT); mem_addr.push_back(req_addr_o); end
      end
    end else m_issue = 1'b0;
  end

  task automatic run_op(input logic ld, input logic [31:0] base, input logic [31:0] stride,
                        input int len, input bit poke, input string tag);
    int prev;
    prev = ops_done;
    @(negedge clk_i);
    req_cnt = 0;
    start_i = 1'b1; load_i = ld; base_i = base; stride_i = stride; vlen_i = 7'(len);
    @(negedge clk_i);
    start_i = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk_i);
      start_i = 1'b1; load_i = ~ld; base_i = 32'hdead_0000; stride_i = 32'd5; vlen_i = 7'd3;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (ops_done == prev) @(negedge clk_i);
    @(negedge clk_i);
    chk(req_cnt == len, tag, req_cnt, len);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: outputs quiet in reset
    chk(!busy_o && !done_o && !req_valid_o && !rsp_valid_o, "R1 reset",
        {busy_o, done_o, req_valid_o, rsp_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !req_valid_o && !rsp_valid_o, "R1 after reset",
        {busy_o, done_o, req_valid_o, rsp_valid_o}, 0);
    run_op(1'b1, 32'h100, 32'd1, 20, 1'b0, "R6 unit load count");
    run_op(1'b1, 32'h40, 32'd16, 6, 1'b0, "R6 same-bank load count");
    run_op(1'b0, 32'h7, 32'd3, 10, 1'b0, "R6 store count");
    run_op(1'b1, 32'h0, 32'd8, 9, 1'b0, "R6 stride8 load count");
    run_op(1'b1, 32'h2, 32'hffff_ffff, 5, 1'b0, "R6 negative stride count");
    run_op(1'b0, 32'h10, 32'd0, 0, 1'b0, "R9 zero length count");
    run_op(1'b1, 32'h300, 32'd2, 12, 1'b1, "R10 start ignored count");
    run_op(1'b0, 32'hffff_fff0, 32'd2, 64, 1'b0, "R6 long store count");
    run_op(1'b1, 32'h55, 32'hffff_fff0, 7, 1'b0, "R6 negative aliasing count");
    run_op(1'b0, 32'h9, 32'd32, 5, 1'b1, "R10 store start ignored count");
    repeat (4) @(negedge clk_i);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule